// File: doc/BRIEF.md
# Sliding-Window Trellis Decoder Schedule Sequencer

This block sequences one soft-in soft-out trellis decoder through a block of equal-length windows. Each window has up to three phases, and they always run in the same order. The first is a forward (alpha) recursion that climbs over every index of the window. The second is a short pre-backward training run that descends over the first few indices of the next window. The third is a backward recursion that descends over the window again and, at each index, also forms the delta metrics and the extrinsic value. Each index costs a fixed number of micro-cycles, so a window has a known cost. With the default sizes (128 indices, 24 training indices, 7/7/24 micro-cycles) a window takes 7·128 + 7·24 + 24·128 = 4136 cycles.

In every cycle the sequencer presents registered outputs: the phase, the bit index, the micro-step within that index and the backward sub-stage. It also presents the strobes that a shared arithmetic datapath needs: the a priori fetch, the write and read-back of alpha state memory, the metric register bank write, the extrinsic write, and the choice of seed for each recursion (fixed start state or carried state). A start pulse loads the number of windows. The last window skips the training run and starts its backward pass from the fixed state. The arithmetic itself is outside this block.

Top module: `sw_sched_ctrl`

## Requirements
- R1: Under synchronous reset, and while idle, `phase` is 0 (idle), `busy` is 0, and every strobe and done flag is 0.
- R2: A `start` seen while idle with `num_win` ≠ 0 puts the block in forward phase (`phase`=1) at index 0, micro 0, window 0 on the next cycle. A `start` with `num_win`=0, or one seen while busy, has no effect.
- R3: The forward phase visits indices 0 to WIN_LEN-1 in ascending order, with FWD_CYC micro-steps (0..FWD_CYC-1) per index. `alpha_wr` pulses on the last micro-step of each index, and `bit_idx` then serves as the alpha address.
- R4: The pre-backward phase (`phase`=2) visits indices PRE_LEN-1 down to 0 of the following window, with PRE_CYC micro-steps per index.
- R5: The backward phase (`phase`=3) visits indices WIN_LEN-1 down to 0, with BETA_CYC+DELTA_CYC+LLR_CYC micro-steps per index. `stage` is 0 (beta) for the first BETA_CYC micro-steps, 1 (delta) for the next DELTA_CYC and 2 (extrinsic) for the rest, and 3 outside this phase. `alpha_rd` pulses on micro-step 0 and `ext_wr` on the last micro-step.
- R6: `apr_rd` pulses on micro-step 0 of every index in every active phase.
- R7: `mbank_wr` pulses on the last micro-step of each forward or pre-backward index. In the backward phase it pulses on the last beta micro-step and on the last delta micro-step.
- R8: `alpha_seed_fixed` pulses at the first forward cycle of window 0, and `alpha_seed_carry` at that cycle of every later window. `beta_seed_fixed` pulses at the first pre-backward cycle and at the first backward cycle of the last window. `beta_seed_carry` pulses at the first backward cycle of every other window. No two seed strobes are ever high together.
- R9: The last window has no pre-backward phase. A non-last window lasts FWD_CYC·WIN_LEN + PRE_CYC·PRE_LEN + BWD_CYC·WIN_LEN cycles (4136 by default). The last window lasts the same minus the training run (3968 by default).
- R10: `win_done` is high in the final cycle of each window, and `blk_done` is high in that same cycle of the last window only. The next window's forward phase starts on the following cycle with no gap. After the last window the block is idle on the following cycle.
- R11: `win_idx` numbers the windows of the current block from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block (sampled while idle) |
| num_win | input | WCNT_W | Number of windows in the block |
| busy | output | 1 | A block is in progress |
| phase | output | 2 | 0 idle, 1 forward, 2 pre-backward, 3 backward |
| bit_idx | output | IDX_W | Current bit index / alpha memory address |
| micro | output | MIC_W | Micro-step within the index |
| stage | output | 2 | Backward sub-stage: 0 beta, 1 delta, 2 extrinsic, 3 none |
| win_idx | output | WCNT_W | Current window number |
| apr_rd | output | 1 | Fetch the a priori pair for `bit_idx` |
| alpha_wr | output | 1 | Write alpha set to state memory at `bit_idx` |
| alpha_rd | output | 1 | Read alpha set from state memory at `bit_idx` |
| ext_wr | output | 1 | Write extrinsic value for `bit_idx` |
| mbank_wr | output | 1 | Write metric register bank |
| alpha_seed_fixed | output | 1 | Load fixed initial alpha state |
| alpha_seed_carry | output | 1 | Keep alpha state from previous window |
| beta_seed_fixed | output | 1 | Load fixed initial beta state |
| beta_seed_carry | output | 1 | Keep beta state left by the training run |
| win_done | output | 1 | Final cycle of a window |
| blk_done | output | 1 | Final cycle of the block |

## Verification
Every output is a register. Its value in cycle t after the start edge is a closed-form function of t, the window count, and the per-phase cycle costs. A start accepted at one rising edge shows index 0 / micro 0 right after that edge, so the bench samples on each falling edge and compares every output in every cycle with that arithmetic model. `win_done` and `blk_done` are due in the last cycle of a window, at offset 4135 for the first default window and 8103 for a two-window default block. The first idle cycle follows directly after. A start injected mid-block must leave the cycle-by-cycle sequence unchanged.

// File: rtl/sw_sched_pkg.sv
package sw_sched_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FWD  = 2'd1,
    PH_PRE  = 2'd2,
    PH_BWD  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_BETA  = 2'd0,
    ST_DELTA = 2'd1,
    ST_LLR   = 2'd2,
    ST_NONE  = 2'd3
  } stage_e;
endpackage

// File: rtl/sw_step_last.sv
// Flags the final micro-step of an index for the given phase.
module sw_step_last
  import sw_sched_pkg::*;
#(
  parameter int FWD_CYC = 7,
  parameter int PRE_CYC = 7,
  parameter int BWD_CYC = 24,
  parameter int MIC_W   = 5
) (
  input  phase_e             ph,
  input  logic [MIC_W-1:0]   micro,
  output logic               last
);
  localparam logic [MIC_W-1:0] FWD_END = MIC_W'(FWD_CYC - 1);
  localparam logic [MIC_W-1:0] PRE_END = MIC_W'(PRE_CYC - 1);
  localparam logic [MIC_W-1:0] BWD_END = MIC_W'(BWD_CYC - 1);

  always_comb begin
    case (ph)
      PH_FWD:  last = (micro == FWD_END);
      PH_PRE:  last = (micro == PRE_END);
      PH_BWD:  last = (micro == BWD_END);
      default: last = 1'b0;
    endcase
  end
endmodule

// File: rtl/sw_seq_next.sv
// Next-state logic: phase, index, micro-step and window counters.
module sw_seq_next
  import sw_sched_pkg::*;
#(
  parameter int WIN_LEN = 128,
  parameter int PRE_LEN = 24,
  parameter int IDX_W   = 7,
  parameter int MIC_W   = 5,
  parameter int WCNT_W  = 8
) (
  input  logic              start,
  input  logic [WCNT_W-1:0] num_win,
  input  phase_e            ph_q,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic [MIC_W-1:0]  mic_q,
  input  logic [WCNT_W-1:0] win_q,
  input  logic [WCNT_W-1:0] tot_q,
  input  logic              mic_last,
  output phase_e            ph_n,
  output logic [IDX_W-1:0]  idx_n,
  output logic [MIC_W-1:0]  mic_n,
  output logic [WCNT_W-1:0] win_n,
  output logic [WCNT_W-1:0] tot_n
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WIN_LEN - 1);
  localparam logic [IDX_W-1:0] PRE_TOP = IDX_W'(PRE_LEN - 1);

  logic last_win;
  assign last_win = (win_q == tot_q - 1'b1);

  always_comb begin
    ph_n  = ph_q;
    idx_n = idx_q;
    mic_n = mic_q;
    win_n = win_q;
    tot_n = tot_q;
    if (ph_q == PH_IDLE) begin
      if (start && (num_win != '0)) begin
        ph_n  = PH_FWD;
        idx_n = '0;
        mic_n = '0;
        win_n = '0;
        tot_n = num_win;
      end
    end else if (!mic_last) begin
      mic_n = mic_q + 1'b1;
    end else begin
      mic_n = '0;
      case (ph_q)
        PH_FWD: begin
          if (idx_q == IDX_TOP) begin
            if (last_win) begin
              ph_n  = PH_BWD;
              idx_n = IDX_TOP;
            end else begin
              ph_n  = PH_PRE;
              idx_n = PRE_TOP;
            end
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
        PH_PRE: begin
          if (idx_q == '0) begin
            ph_n  = PH_BWD;
            idx_n = IDX_TOP;
          end else begin
            idx_n = idx_q - 1'b1;
          end
        end
        PH_BWD: begin
          if (idx_q == '0) begin
            if (last_win) begin
              ph_n = PH_IDLE;
            end else begin
              ph_n  = PH_FWD;
              win_n = win_q + 1'b1;
            end
          end else begin
            idx_n = idx_q - 1'b1;
          end
        end
        default: ph_n = PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sw_strobe_dec.sv
// Decodes a (next) schedule state into datapath strobes.
module sw_strobe_dec
  import sw_sched_pkg::*;
#(
  parameter int WIN_LEN   = 128,
  parameter int PRE_LEN   = 24,
  parameter int BETA_CYC  = 7,
  parameter int DELTA_CYC = 4,
  parameter int IDX_W     = 7,
  parameter int MIC_W     = 5,
  parameter int WCNT_W    = 8
) (
  input  phase_e            ph,
  input  logic [IDX_W-1:0]  idx,
  input  logic [MIC_W-1:0]  micro,
  input  logic [WCNT_W-1:0] win,
  input  logic [WCNT_W-1:0] tot,
  input  logic              mic_last,
  output stage_e            stage,
  output logic              busy,
  output logic              apr_rd,
  output logic              alpha_wr,
  output logic              alpha_rd,
  output logic              ext_wr,
  output logic              mbank_wr,
  output logic              alpha_seed_fixed,
  output logic              alpha_seed_carry,
  output logic              beta_seed_fixed,
  output logic              beta_seed_carry,
  output logic              win_done,
  output logic              blk_done
);
  localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(WIN_LEN - 1);
  localparam logic [IDX_W-1:0] PRE_TOP   = IDX_W'(PRE_LEN - 1);
  localparam logic [MIC_W-1:0] BETA_END  = MIC_W'(BETA_CYC - 1);
  localparam logic [MIC_W-1:0] DELTA_END = MIC_W'(BETA_CYC + DELTA_CYC - 1);

  logic first_mic, last_win, fwd_start, bwd_start, pre_start, in_bwd;

  assign first_mic = (micro == '0);
  assign last_win  = (win == tot - 1'b1);
  assign in_bwd    = (ph == PH_BWD);
  assign fwd_start = (ph == PH_FWD) && (idx == '0) && first_mic;
  assign pre_start = (ph == PH_PRE) && (idx == PRE_TOP) && first_mic;
  assign bwd_start = in_bwd && (idx == IDX_TOP) && first_mic;

  always_comb begin
    if (!in_bwd)                stage = ST_NONE;
    else if (micro <= BETA_END)  stage = ST_BETA;
    else if (micro <= DELTA_END) stage = ST_DELTA;
    else                         stage = ST_LLR;
  end

  assign busy             = (ph != PH_IDLE);
  assign apr_rd           = busy && first_mic;
  assign alpha_wr         = (ph == PH_FWD) && mic_last;
  assign alpha_rd         = in_bwd && first_mic;
  assign ext_wr           = in_bwd && mic_last;
  assign mbank_wr         = (((ph == PH_FWD) || (ph == PH_PRE)) && mic_last)
                          || (in_bwd && ((micro == BETA_END) || (micro == DELTA_END)));
  assign alpha_seed_fixed = fwd_start && (win == '0);
  assign alpha_seed_carry = fwd_start && (win != '0);
  assign beta_seed_fixed  = pre_start || (bwd_start && last_win);
  assign beta_seed_carry  = bwd_start && !last_win;
  assign win_done         = in_bwd && (idx == '0) && mic_last;
  assign blk_done         = win_done && last_win;
endmodule

// File: rtl/sw_sched_ctrl.sv
// Top: state registers plus registered strobes decoded from next state.
module sw_sched_ctrl
  import sw_sched_pkg::*;
#(
  parameter int WIN_LEN   = 128,
  parameter int PRE_LEN   = 24,
  parameter int FWD_CYC   = 7,
  parameter int PRE_CYC   = 7,
  parameter int BETA_CYC  = 7,
  parameter int DELTA_CYC = 4,
  parameter int LLR_CYC   = 13,
  parameter int WCNT_W    = 8,
  localparam int BWD_CYC  = BETA_CYC + DELTA_CYC + LLR_CYC,
  localparam int MAX_CYC  = (BWD_CYC > FWD_CYC)
                            ? ((BWD_CYC > PRE_CYC) ? BWD_CYC : PRE_CYC)
                            : ((FWD_CYC > PRE_CYC) ? FWD_CYC : PRE_CYC),
  localparam int IDX_W    = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1,
  localparam int MIC_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WCNT_W-1:0] num_win,
  output logic              busy,
  output logic [1:0]        phase,
  output logic [IDX_W-1:0]  bit_idx,
  output logic [MIC_W-1:0]  micro,
  output logic [1:0]        stage,
  output logic [WCNT_W-1:0] win_idx,
  output logic              apr_rd,
  output logic              alpha_wr,
  output logic              alpha_rd,
  output logic              ext_wr,
  output logic              mbank_wr,
  output logic              alpha_seed_fixed,
  output logic              alpha_seed_carry,
  output logic              beta_seed_fixed,
  output logic              beta_seed_carry,
  output logic              win_done,
  output logic              blk_done
);
  phase_e            ph_q, ph_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [MIC_W-1:0]  mic_q, mic_n;
  logic [WCNT_W-1:0] win_q, win_n, tot_q, tot_n;
  logic              last_cur, last_nxt;

  stage_e stage_d;
  logic   busy_d, apr_d, awr_d, ard_d, ewr_d, mbw_d;
  logic   asf_d, asc_d, bsf_d, bsc_d, wd_d, bd_d;

  sw_step_last #(
    .FWD_CYC(FWD_CYC), .PRE_CYC(PRE_CYC), .BWD_CYC(BWD_CYC), .MIC_W(MIC_W)
  ) u_step_cur (
    .ph(ph_q), .micro(mic_q), .last(last_cur)
  );

  sw_step_last #(
    .FWD_CYC(FWD_CYC), .PRE_CYC(PRE_CYC), .BWD_CYC(BWD_CYC), .MIC_W(MIC_W)
  ) u_step_nxt (
    .ph(ph_n), .micro(mic_n), .last(last_nxt)
  );

  sw_seq_next #(
    .WIN_LEN(WIN_LEN), .PRE_LEN(PRE_LEN), .IDX_W(IDX_W),
    .MIC_W(MIC_W), .WCNT_W(WCNT_W)
  ) u_seq (
    .start(start), .num_win(num_win),
    .ph_q(ph_q), .idx_q(idx_q), .mic_q(mic_q), .win_q(win_q), .tot_q(tot_q),
    .mic_last(last_cur),
    .ph_n(ph_n), .idx_n(idx_n), .mic_n(mic_n), .win_n(win_n), .tot_n(tot_n)
  );

  sw_strobe_dec #(
    .WIN_LEN(WIN_LEN), .PRE_LEN(PRE_LEN), .BETA_CYC(BETA_CYC),
    .DELTA_CYC(DELTA_CYC), .IDX_W(IDX_W), .MIC_W(MIC_W), .WCNT_W(WCNT_W)
  ) u_dec (
    .ph(ph_n), .idx(idx_n), .micro(mic_n), .win(win_n), .tot(tot_n),
    .mic_last(last_nxt),
    .stage(stage_d), .busy(busy_d), .apr_rd(apr_d), .alpha_wr(awr_d),
    .alpha_rd(ard_d), .ext_wr(ewr_d), .mbank_wr(mbw_d),
    .alpha_seed_fixed(asf_d), .alpha_seed_carry(asc_d),
    .beta_seed_fixed(bsf_d), .beta_seed_carry(bsc_d),
    .win_done(wd_d), .blk_done(bd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q             <= PH_IDLE;
      idx_q            <= '0;
      mic_q            <= '0;
      win_q            <= '0;
      tot_q            <= '0;
      stage            <= ST_NONE;
      busy             <= 1'b0;
      apr_rd           <= 1'b0;
      alpha_wr         <= 1'b0;
      alpha_rd         <= 1'b0;
      ext_wr           <= 1'b0;
      mbank_wr         <= 1'b0;
      alpha_seed_fixed <= 1'b0;
      alpha_seed_carry <= 1'b0;
      beta_seed_fixed  <= 1'b0;
      beta_seed_carry  <= 1'b0;
      win_done         <= 1'b0;
      blk_done         <= 1'b0;
    end else begin
      ph_q             <= ph_n;
      idx_q            <= idx_n;
      mic_q            <= mic_n;
      win_q            <= win_n;
      tot_q            <= tot_n;
      stage            <= stage_d;
      busy             <= busy_d;
      apr_rd           <= apr_d;
      alpha_wr         <= awr_d;
      alpha_rd         <= ard_d;
      ext_wr           <= ewr_d;
      mbank_wr         <= mbw_d;
      alpha_seed_fixed <= asf_d;
      alpha_seed_carry <= asc_d;
      beta_seed_fixed  <= bsf_d;
      beta_seed_carry  <= bsc_d;
      win_done         <= wd_d;
      blk_done         <= bd_d;
    end
  end

  assign phase   = ph_q;
  assign bit_idx = idx_q;
  assign micro   = mic_q;
  assign win_idx = win_q;
endmodule

// File: rtl/sw_sched_ctrl_chk.sv
module sw_sched_ctrl_chk #(
  parameter int WIN_LEN = 128,
  parameter int IDX_W   = 7,
  parameter int MIC_W   = 5,
  parameter int WCNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [WCNT_W-1:0] num_win,
  input logic              busy,
  input logic [1:0]        phase,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [MIC_W-1:0]  micro,
  input logic              alpha_wr,
  input logic              ext_wr,
  input logic              alpha_seed_fixed,
  input logic              alpha_seed_carry,
  input logic              beta_seed_fixed,
  input logic              beta_seed_carry,
  input logic              win_done,
  input logic              blk_done
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WIN_LEN - 1);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0) |-> !(alpha_wr || ext_wr || win_done || busy)); // R1
  AST_START_FWD: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && start && num_win != '0)
      |=> (phase == 2'd1 && bit_idx == '0 && micro == '0)); // R2
  AST_FWD_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1 && micro == '0 && bit_idx != '0)
      |-> ($past(bit_idx) + 1'b1 == bit_idx)); // R3
  AST_MICRO_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd0 && micro != '0) |-> (micro == $past(micro) + 1'b1)); // R4
  AST_BWD_DESCEND: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd3 && micro == '0 && bit_idx != IDX_TOP)
      |-> ($past(bit_idx) == bit_idx + 1'b1)); // R5
  AST_SEED_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({alpha_seed_fixed, alpha_seed_carry,
              beta_seed_fixed, beta_seed_carry})); // R8
  AST_BLK_IN_WIN: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> win_done); // R10
  AST_BLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> (phase == 2'd0 && !busy)); // R10
  AST_WIN_NEXT: assert property (@(posedge clk) disable iff (rst)
    (win_done && !blk_done)
      |=> (phase == 2'd1 && bit_idx == '0 && micro == '0)); // R10
endmodule

bind sw_sched_ctrl sw_sched_ctrl_chk #(
  .WIN_LEN(WIN_LEN), .IDX_W(IDX_W), .MIC_W(MIC_W), .WCNT_W(WCNT_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .num_win(num_win), .busy(busy),
  .phase(phase), .bit_idx(bit_idx), .micro(micro),
  .alpha_wr(alpha_wr), .ext_wr(ext_wr),
  .alpha_seed_fixed(alpha_seed_fixed), .alpha_seed_carry(alpha_seed_carry),
  .beta_seed_fixed(beta_seed_fixed), .beta_seed_carry(beta_seed_carry),
  .win_done(win_done), .blk_done(blk_done)
);

// File: tb/sw_sched_ctrl_bench.sv
module sw_sched_ctrl_bench;
  localparam int SL = 8, SP = 3, FC = 7, PC = 7, BB = 7, BD = 4, BL = 13;
  localparam int BC = BB + BD + BL;
  localparam int WN = FC * SL + PC * SP + BC * SL;
  localparam int WL = FC * SL + BC * SL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // small configuration
  logic       start = 1'b0;
  logic [3:0] nw = '0;
  logic       busy, apr, awr, ard, ewr, mbw, asf, asc, bsf, bsc, wd, bd;
  logic [1:0] ph, stg;
  logic [2:0] idx;
  logic [4:0] mic;
  logic [3:0] win;

  sw_sched_ctrl #(.WIN_LEN(SL), .PRE_LEN(SP), .WCNT_W(4)) u_sw_sched_ctrl (
    .clk(clk), .rst(rst), .start(start), .num_win(nw), .busy(busy),
    .phase(ph), .bit_idx(idx), .micro(mic), .stage(stg), .win_idx(win),
    .apr_rd(apr), .alpha_wr(awr), .alpha_rd(ard), .ext_wr(ewr),
    .mbank_wr(mbw), .alpha_seed_fixed(asf), .alpha_seed_carry(asc),
    .beta_seed_fixed(bsf), .beta_seed_carry(bsc),
    .win_done(wd), .blk_done(bd)
  );

  // default configuration
  logic       start2 = 1'b0;
  logic [7:0] nw2 = '0;
  logic       busy2, apr2, awr2, ard2, ewr2, mbw2, asf2, asc2, bsf2, bsc2, wd2, bd2;
  logic [1:0] ph2, stg2;
  logic [6:0] idx2;
  logic [4:0] mic2;
  logic [7:0] win2;

  sw_sched_ctrl u_sw_sched_ctrl_dflt (
    .clk(clk), .rst(rst), .start(start2), .num_win(nw2), .busy(busy2),
    .phase(ph2), .bit_idx(idx2), .micro(mic2), .stage(stg2), .win_idx(win2),
    .apr_rd(apr2), .alpha_wr(awr2), .alpha_rd(ard2), .ext_wr(ewr2),
    .mbank_wr(mbw2), .alpha_seed_fixed(asf2), .alpha_seed_carry(asc2),
    .beta_seed_fixed(bsf2), .beta_seed_carry(bsc2),
    .win_done(wd2), .blk_done(bd2)
  );

  task automatic chk(input string tag, input int t, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s t=%0d got %0d exp %0d", tag, t, got, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 got %0d exp %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // Arithmetic model of cycle t (0 = first cycle after the start edge).
  task automatic check_cycle(input int t, input int n);
    int w, o, b, eph, eidx, emic, estg, ncyc;
    bit lastw, mlast;
    string tg;
    w = t / WN;
    if (w >= n - 1) begin w = n - 1; o = t - (n - 1) * WN; end
    else o = t - w * WN;
    lastw = (w == n - 1);
    if (o < FC * SL) begin
      eph = 1; eidx = o / FC; emic = o % FC; ncyc = FC; tg = "R3";
    end else if (!lastw && o < FC * SL + PC * SP) begin
      eph = 2; eidx = SP - 1 - (o - FC * SL) / PC; emic = (o - FC * SL) % PC;
      ncyc = PC; tg = "R4";
    end else begin
      b = o - (lastw ? FC * SL : FC * SL + PC * SP);
      eph = 3; eidx = SL - 1 - b / BC; emic = b % BC; ncyc = BC; tg = "R5";
    end
    mlast = (emic == ncyc - 1);
    estg = (eph != 3) ? 3 : (emic < BB) ? 0 : (emic < BB + BD) ? 1 : 2;
    chk(tg, t, int'(ph), eph);
    chk(tg, t, int'(idx), eidx);
    chk(tg, t, int'(mic), emic);
    chk("R5", t, int'(stg), estg);
    chk("R2", t, int'(busy), 1);
    chk("R11", t, int'(win), w);
    chk("R6", t, int'(apr), int'(emic == 0));
    chk("R3", t, int'(awr), int'(eph == 1 && mlast));
    chk("R5", t, int'(ard), int'(eph == 3 && emic == 0));
    chk("R5", t, int'(ewr), int'(eph == 3 && mlast));
    chk("R7", t, int'(mbw), int'((eph != 3 && mlast) ||
                                 (eph == 3 && (emic == BB - 1 || emic == BB + BD - 1))));
    chk("R8", t, int'(asf), int'(eph == 1 && eidx == 0 && emic == 0 && w == 0));
    chk("R8", t, int'(asc), int'(eph == 1 && eidx == 0 && emic == 0 && w != 0));
    chk("R8", t, int'(bsf), int'((eph == 2 && eidx == SP - 1 && emic == 0) ||
                                 (eph == 3 && eidx == SL - 1 && emic == 0 && lastw)));
    chk("R8", t, int'(bsc), int'(eph == 3 && eidx == SL - 1 && emic == 0 && !lastw));
    chk("R10", t, int'(wd), int'(eph == 3 && eidx == 0 && mlast));
    chk("R10", t, int'(bd), int'(eph == 3 && eidx == 0 && mlast && lastw));
  endtask

  task automatic check_idle(input string tg, input int t);
    chk(tg, t, int'(ph), 0);
    chk(tg, t, int'(busy), 0);
    chk(tg, t, int'({apr, awr, ard, ewr, mbw, asf, asc, bsf, bsc, wd, bd}), 0);
  endtask

  initial begin
    int wd_at, bd_at, bsc_at, busy_cnt, ph_next;
    repeat (3) @(negedge clk);
    check_idle("R1", -1);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1", -1);

    // start with zero windows is ignored (R2)
    nw = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check_idle("R2", -1);

    for (int n = 1; n <= 3; n++) begin
      int total;
      total = (n - 1) * WN + WL;
      nw = 4'(n); start = 1'b1;
      for (int t = 0; t < total; t++) begin
        @(negedge clk);
        if (t == 0) start = 1'b0;
        check_cycle(t, n);
        if (n == 2 && t == 100) begin start = 1'b1; nw = 4'd5; end  // ignored: R2
        if (n == 2 && t == 101) start = 1'b0;
      end
      @(negedge clk);
      check_idle("R10", total);
      @(negedge clk);
    end

    // default sizes, two windows (R9)
    wd_at = -1; bd_at = -1; bsc_at = -1; busy_cnt = 0; ph_next = -1;
    nw2 = 8'd2; start2 = 1'b1;
    for (int t = 0; t < 8200; t++) begin
      @(negedge clk);
      if (t == 0) start2 = 1'b0;
      if (busy2) busy_cnt++;
      if (wd2 && wd_at < 0) wd_at = t;
      if (bd2) bd_at = t;
      if (bsc2 && bsc_at < 0) bsc_at = t;
      if (t == 4136) ph_next = int'(ph2) * 256 + int'(win2);
    end
    chk("R9", 0, wd_at, 4135);
    chk("R9", 0, bd_at, 8103);
    chk("R9", 0, busy_cnt, 8104);
    chk("R8", 0, bsc_at, 7 * 128 + 7 * 24);
    chk("R10", 0, ph_next, 1 * 256 + 1);

    summary();
    $finish;
  end
endmodule